// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the controller-side state machine for one byte-wide NAND flash channel shared by four banks. A host presents one operation request (operation code, bank, page, column, and two flags). The sequencer then plays the matching command, address and data cycles onto the flash bus, using one strobe cycle per byte. It finishes by pulsing `done`, and it raises `err` in the same cycle if a wait expired. Five operations are supported: device reset, identifier read, page read, page program and block erase.

Busy operations do not rely on the ready/busy pin. Instead, the sequencer issues the status command and keeps reading the status byte until its ready bit is set. It then issues the plain read command so that the device returns array data again. Each wait is bounded by a fixed timeout, derived from the clock rate and a time in milliseconds. Page data flows through a simple streaming byte port. Buffering, DMA and error correction stay in the host.

Top module: `nand_seq`

## Requirements
- R1: Operation code 0 (reset) issues command 0xFF and then waits for the bank's `nf_rdy` bit to be high. It then pulses `fifo_clr` for one cycle and completes without error.
- R2: Operation code 1 (identifier read) issues command 0x90 and one address byte 0x00. It then performs four read strobes, and the first byte read lands in `id_word[7:0]`, the next in `[15:8]`, and so on.
- R3: Operation code 2 (page read) issues 0x00, then two column bytes low first, then three page bytes low first, then 0x30. It then issues 0x70 and reads status bytes until bit 6 is set, with every other status bit ignored. It then issues 0x00 and delivers 2112 bytes on `rd_valid`/`rd_data`, in the order they were read.
- R4: With `req_spare_only` set, a read or program uses column 0x0800 whatever `req_col` holds, and transfers only the 64 spare bytes.
- R5: Operation code 3 (program) issues 0x80, then the five address bytes, then one data strobe per `wr_take` cycle carrying `wr_data`, then 0x10. With `req_wait` set it then polls status and exits with 0x00 as in R3. With `req_wait` clear it completes right after 0x10 with no status read.
- R6: Operation code 4 (erase) issues 0x60, then only the three page bytes low first, then 0xD0. It then polls status and issues 0x00.
- R7: If the ready indication or the status ready bit has not appeared within CLK_KHZ*TIMEOUT_MS cycles, the operation ends with `done` and `err` high. No further command is issued.
- R8: While an operation runs, exactly the chip-enable `nf_ce_n[bank]` is low. In idle all four chip enables are high.
- R9: A request is taken only when `req_ready` is high. A request made during an operation is ignored, so the running bank, sequence and single completion are unchanged.
- R10: `done` is high for exactly one cycle per operation, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 3 | Operation: 0 reset, 1 identifier, 2 read, 3 program, 4 erase |
| req_bank | input | 2 | Target bank |
| req_page | input | 24 | Page (row) address |
| req_col | input | 16 | Column offset |
| req_spare_only | input | 1 | Transfer only the spare area |
| req_wait | input | 1 | Program: wait for ready after confirm |
| req_ready | output | 1 | Sequencer idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout error, valid with done |
| id_word | output | 32 | Identifier captured by operation 1 |
| wr_data | input | 8 | Program byte stream from host |
| wr_take | output | 1 | wr_data is consumed this cycle |
| rd_valid | output | 1 | rd_data holds a read byte |
| rd_data | output | 8 | Read byte stream to host |
| fifo_clr | output | 1 | Pulse telling the host to flush its byte FIFOs |
| nf_ce_n | output | 4 | Active-low chip enables, one per bank |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Active-low write strobe |
| nf_re_n | output | 1 | Active-low read strobe |
| nf_dout | output | 8 | Byte driven to the flash |
| nf_din | input | 8 | Byte returned by the flash |
| nf_rdy | input | 4 | Per-bank ready indication (high = ready) |

## Verification
Each operation is driven against a behavioural flash model, and the complete command/address byte log is compared. This separates operations whose command bytes are the same but whose address length or confirm differs. Reads and programs stream known byte ramps, so reordered, dropped or extra bytes show up. Spare-only mode tells the column override apart from a plain column. Status bytes with every bit set except the ready bit prove that only bit 6 is decoded. A never-ready device and a stuck ready line exercise both timeout paths, and a request injected mid-read shows that busy requests are ignored.

// File: rtl/nand_seq_pkg.sv
// Shared types and flash opcodes for the NAND command sequencer.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_RESET  = 3'd0,
        OP_READID = 3'd1,
        OP_READ   = 3'd2,
        OP_PROG   = 3'd3,
        OP_ERASE  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_STCMD,
        S_STRD, S_EXIT, S_RDATA, S_IDRD, S_RBWAIT, S_DONE
    } state_e;

    localparam logic [7:0] FC_RESET      = 8'hFF;
    localparam logic [7:0] FC_READID     = 8'h90;
    localparam logic [7:0] FC_READ_SETUP = 8'h00;
    localparam logic [7:0] FC_READ_GO    = 8'h30;
    localparam logic [7:0] FC_PROG_SETUP = 8'h80;
    localparam logic [7:0] FC_PROG_GO    = 8'h10;
    localparam logic [7:0] FC_ERASE_SETUP= 8'h60;
    localparam logic [7:0] FC_ERASE_GO   = 8'hD0;
    localparam logic [7:0] FC_STATUS     = 8'h70;
    localparam int         STAT_RDY_BIT  = 6;

endpackage

// File: rtl/nand_seq_timer.sv
// Wait-step watchdog: counts cycles while run is high, saturates at LIMIT.
// Assumes clear is asserted whenever the sequencer is outside a wait state.
module nand_seq_timer #(
    parameter int LIMIT = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    assign expired = (cnt == TW'(LIMIT));

    // Count cycles spent in the current wait; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (run && !expired) cnt <= cnt + 1'b1;
    end

    // R7
    timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);

    // R7
    timeout_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);

endmodule

// File: rtl/nand_seq_addr.sv
// Address byte selector: returns byte idx of the column+row address,
// column bytes first then row bytes, each low byte first. With row_only
// the column bytes are skipped. Assumes idx stays inside the used range.
module nand_seq_addr #(
    parameter int COL_W = 16,
    parameter int ROW_W = 24,
    parameter int IDX_W = 3
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [IDX_W-1:0] idx,
    input  logic             row_only,
    output logic [7:0]       abyte
);
    localparam int COL_B = (COL_W + 7) / 8;
    localparam int ROW_B = (ROW_W + 7) / 8;

    logic [COL_B*8-1:0]         col_p;
    logic [ROW_B*8-1:0]         row_p;
    logic [(COL_B+ROW_B)*8-1:0] all_b;
    logic [IDX_W-1:0]           sel;

    // Pad the fields to whole bytes and pick the requested byte.
    always_comb begin
        col_p = '0;
        col_p[COL_W-1:0] = col;
        row_p = '0;
        row_p[ROW_W-1:0] = row;
        all_b = {row_p, col_p};
        sel   = row_only ? idx + IDX_W'(COL_B) : idx;
        abyte = all_b[int'(sel)*8 +: 8];
    end

endmodule

// File: rtl/nand_seq.sv
// NAND command sequencer top. Accepts one request in idle, drives the
// command/address/data cycles (one strobe cycle per byte), finishes busy
// operations by status polling, and reports done/err. Assumes nf_rdy and
// nf_din are synchronous to clk and the host keeps wr_data valid whenever
// wr_take is high.
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int NBANK       = 4,
    parameter int ROW_W       = 24,
    parameter int COL_W       = 16,
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int CLK_KHZ     = 100000,
    parameter int TIMEOUT_MS  = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_op,
    input  logic [$clog2(NBANK)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_page,
    input  logic [COL_W-1:0]         req_col,
    input  logic                     req_spare_only,
    input  logic                     req_wait,
    output logic                     req_ready,
    output logic                     done,
    output logic                     err,
    output logic [31:0]              id_word,
    input  logic [7:0]               wr_data,
    output logic                     wr_take,
    output logic                     rd_valid,
    output logic [7:0]               rd_data,
    output logic                     fifo_clr,
    output logic [NBANK-1:0]         nf_ce_n,
    output logic                     nf_cle,
    output logic                     nf_ale,
    output logic                     nf_we_n,
    output logic                     nf_re_n,
    output logic [7:0]               nf_dout,
    input  logic [7:0]               nf_din,
    input  logic [NBANK-1:0]         nf_rdy
);
    localparam int BANK_W     = $clog2(NBANK);
    localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
    localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
    localparam int COL_B      = (COL_W + 7) / 8;
    localparam int ROW_B      = (ROW_W + 7) / 8;
    localparam int IDX_W      = $clog2(COL_B + ROW_B + 1);
    localparam int LIMIT      = CLK_KHZ * TIMEOUT_MS;
    localparam int ID_BYTES   = 4;

    state_e             state;
    op_e                op_q;
    logic [BANK_W-1:0]  bank_q;
    logic [ROW_W-1:0]   page_q;
    logic [COL_W-1:0]   col_q;
    logic               spare_q, wait_q, err_q;
    logic [CNT_W-1:0]   cnt, alen, nbytes;
    logic [31:0]        id_q;
    logic [7:0]         abyte;
    logic [COL_W-1:0]   col_eff;
    logic               expired, in_wait;

    // Operation-dependent lengths and the effective column.
    always_comb begin
        col_eff = spare_q ? COL_W'(DATA_BYTES) : col_q;
        nbytes  = spare_q ? CNT_W'(SPARE_BYTES) : CNT_W'(PAGE_BYTES);
        case (op_q)
            OP_READID: alen = CNT_W'(1);
            OP_ERASE:  alen = CNT_W'(ROW_B);
            default:   alen = CNT_W'(COL_B + ROW_B);
        endcase
    end

    nand_seq_addr #(.COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_addr (
        .col(col_eff), .row(page_q), .idx(cnt[IDX_W-1:0]),
        .row_only(op_q == OP_ERASE), .abyte(abyte)
    );

    assign in_wait = (state == S_STRD) || (state == S_RBWAIT);

    nand_seq_timer #(.LIMIT(LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(!in_wait), .run(in_wait),
        .expired(expired)
    );

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_RESET;
            bank_q   <= '0;
            page_q   <= '0;
            col_q    <= '0;
            spare_q  <= 1'b0;
            wait_q   <= 1'b0;
            err_q    <= 1'b0;
            cnt      <= '0;
            id_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            fifo_clr <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            fifo_clr <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    op_q    <= op_e'(req_op);
                    bank_q  <= req_bank;
                    page_q  <= req_page;
                    col_q   <= req_col;
                    spare_q <= req_spare_only;
                    wait_q  <= req_wait;
                    err_q   <= 1'b0;
                    cnt     <= '0;
                    state   <= S_CMD1;
                end
                S_CMD1: begin
                    cnt   <= '0;
                    state <= (op_q == OP_RESET) ? S_RBWAIT : S_ADDR;
                end
                S_ADDR: if (cnt == alen - 1'b1) begin
                    cnt <= '0;
                    case (op_q)
                        OP_READID: state <= S_IDRD;
                        OP_PROG:   state <= S_WDATA;
                        default:   state <= S_CMD2;
                    endcase
                end else cnt <= cnt + 1'b1;
                S_WDATA: if (cnt == nbytes - 1'b1) begin
                    cnt   <= '0;
                    state <= S_CMD2;
                end else cnt <= cnt + 1'b1;
                S_CMD2:  state <= (op_q == OP_PROG && !wait_q) ? S_DONE : S_STCMD;
                S_STCMD: state <= S_STRD;
                S_STRD: if (nf_din[STAT_RDY_BIT]) state <= S_EXIT;
                        else if (expired) begin
                            err_q <= 1'b1;
                            state <= S_DONE;
                        end
                S_EXIT: begin
                    cnt   <= '0;
                    state <= (op_q == OP_READ) ? S_RDATA : S_DONE;
                end
                S_RDATA: begin
                    rd_valid <= 1'b1;
                    rd_data  <= nf_din;
                    if (cnt == nbytes - 1'b1) state <= S_DONE;
                    cnt <= cnt + 1'b1;
                end
                S_IDRD: begin
                    id_q[int'(cnt[1:0])*8 +: 8] <= nf_din;
                    if (cnt == CNT_W'(ID_BYTES - 1)) state <= S_DONE;
                    cnt <= cnt + 1'b1;
                end
                S_RBWAIT: if (nf_rdy[bank_q]) begin
                    fifo_clr <= 1'b1;
                    state    <= S_DONE;
                end else if (expired) begin
                    err_q <= 1'b1;
                    state <= S_DONE;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Bus strobes and handshake outputs decoded from the current state.
    always_comb begin
        req_ready = (state == S_IDLE);
        done      = (state == S_DONE);
        err       = done && err_q;
        id_word   = id_q;
        wr_take   = (state == S_WDATA);
        nf_cle    = (state == S_CMD1) || (state == S_CMD2) ||
                    (state == S_STCMD) || (state == S_EXIT);
        nf_ale    = (state == S_ADDR);
        nf_we_n   = !(nf_cle || nf_ale || wr_take);
        nf_re_n   = !((state == S_STRD) || (state == S_RDATA) || (state == S_IDRD));
        case (state)
            S_CMD1: case (op_q)
                OP_RESET:  nf_dout = FC_RESET;
                OP_READID: nf_dout = FC_READID;
                OP_READ:   nf_dout = FC_READ_SETUP;
                OP_PROG:   nf_dout = FC_PROG_SETUP;
                default:   nf_dout = FC_ERASE_SETUP;
            endcase
            S_CMD2: case (op_q)
                OP_READ:   nf_dout = FC_READ_GO;
                OP_PROG:   nf_dout = FC_PROG_GO;
                default:   nf_dout = FC_ERASE_GO;
            endcase
            S_STCMD: nf_dout = FC_STATUS;
            S_EXIT:  nf_dout = FC_READ_SETUP;
            S_ADDR:  nf_dout = (op_q == OP_READID) ? 8'h00 : abyte;
            S_WDATA: nf_dout = wr_data;
            default: nf_dout = 8'h00;
        endcase
    end

    // One active-low enable per bank, low only for the latched bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_ce
        assign nf_ce_n[b] = !((state != S_IDLE) && (bank_q == BANK_W'(b)));
    end

    // R8
    ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> $onehot(~nf_ce_n));

    // R8
    ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&nf_ce_n));

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && req_valid) |=> $stable(bank_q));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> (nf_re_n && !(nf_cle && nf_ale)));

    // R7
    no_cmd_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (nf_we_n && nf_re_n));

endmodule

// File: tb/test_nand_seq.sv
// Directed bench for nand_seq with a behavioural flash model.
module test_nand_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 200;   // CLK_KHZ 10 * TIMEOUT_MS 20

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_spare_only = 1'b0, req_wait = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_bank = '0;
    logic [23:0] req_page = '0;
    logic [15:0] req_col = '0;
    logic        req_ready, done, err, wr_take, rd_valid, fifo_clr;
    logic [31:0] id_word;
    logic [7:0]  wr_data, rd_data, nf_dout, nf_din;
    logic [3:0]  nf_ce_n, nf_rdy = 4'hF;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_seq #(.CLK_KHZ(10), .TIMEOUT_MS(20)) i_nand_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_page(req_page), .req_col(req_col),
        .req_spare_only(req_spare_only), .req_wait(req_wait),
        .req_ready(req_ready), .done(done), .err(err), .id_word(id_word),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid),
        .rd_data(rd_data), .fifo_clr(fifo_clr), .nf_ce_n(nf_ce_n),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dout(nf_dout), .nf_din(nf_din), .nf_rdy(nf_rdy)
    );

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- flash model and bus monitor ----------------
    localparam int M_DATA = 0, M_STAT = 1, M_ID = 2;
    int          dev_mode = M_DATA, rcnt = 0, polls_needed = 0;
    logic [31:0] dev_id = 32'h9510DAEC;
    logic [9:0]  log_q [32];
    int log_n, wr_seen, wr_bad, rd_seen, rd_bad, stat_reads, wtk;
    int clr_n, done_n, err_lone, done_long, ce_viol;
    logic done_prev;
    logic mon_clr = 1'b0;
    int   cur_bank = 0;

    assign wr_data = 8'(wtk * 5 + 1);

    always_comb begin
        case (dev_mode)
            M_STAT:  nf_din = (rcnt >= polls_needed) ? 8'h40 : 8'hBF;
            M_ID:    nf_din = dev_id[(rcnt % 4)*8 +: 8];
            default: nf_din = 8'(rcnt * 7 + 3);
        endcase
    end

    always @(posedge clk) begin
        if (mon_clr || !rst_n) begin
            log_n <= 0; wr_seen <= 0; wr_bad <= 0; rd_seen <= 0; rd_bad <= 0;
            stat_reads <= 0; wtk <= 0; clr_n <= 0; done_n <= 0; err_lone <= 0;
            done_long <= 0; ce_viol <= 0; done_prev <= 1'b0;
        end else begin
            if (!nf_we_n) begin
                if (nf_cle || nf_ale) begin
                    if (log_n < 32) log_q[log_n] <= {nf_cle, nf_ale, nf_dout};
                    log_n <= log_n + 1;
                end else begin
                    if (nf_dout != 8'(wr_seen * 5 + 1)) wr_bad <= wr_bad + 1;
                    wr_seen <= wr_seen + 1;
                end
            end
            if (wr_take) wtk <= wtk + 1;
            if (!nf_re_n && dev_mode == M_STAT) stat_reads <= stat_reads + 1;
            if (rd_valid) begin
                if (rd_data != 8'(rd_seen * 7 + 3)) rd_bad <= rd_bad + 1;
                rd_seen <= rd_seen + 1;
            end
            if (fifo_clr) clr_n <= clr_n + 1;
            if (done) done_n <= done_n + 1;
            if (err && !done) err_lone <= err_lone + 1;
            if (done && done_prev) done_long <= done_long + 1;
            done_prev <= done;
            if (!req_ready) begin
                if (nf_ce_n != ~(4'b0001 << cur_bank)) ce_viol <= ce_viol + 1;
            end else if (nf_ce_n != 4'hF) ce_viol <= ce_viol + 1;
        end
        // device mode tracking
        if (!nf_we_n && nf_cle) begin
            rcnt <= 0;
            dev_mode <= (nf_dout == 8'h70) ? M_STAT :
                        (nf_dout == 8'h90) ? M_ID : M_DATA;
        end else if (!nf_re_n) rcnt <= rcnt + 1;
    end

    // ---------------- expected log ----------------
    logic [9:0] exp_q [32];
    int exp_n;
    function automatic logic [9:0] C(input logic [7:0] b); return {2'b10, b}; endfunction
    function automatic logic [9:0] A(input logic [7:0] b); return {2'b01, b}; endfunction
    task automatic ex(input logic [9:0] e); exp_q[exp_n] = e; exp_n++; endtask

    task automatic check_log(input string tag);
        int bad = 0;
        chk(log_n == exp_n, tag, "cmd/addr cycle count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_q[i] !== exp_q[i]) begin
                if (bad == 0) chk(1'b0, tag, $sformatf("log entry %0d", i), log_q[i], exp_q[i]);
                bad++;
            end
        if (bad == 0) chk(1'b1, tag, "log entries", 0, 0);
    endtask

    // ---------------- request helpers ----------------
    task automatic clear_mon();
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
        exp_n = 0;
    endtask

    task automatic start_op(input int op, input int bank, input logic [23:0] page,
                            input logic [15:0] col, input bit spare, input bit wt);
        @(negedge clk);
        cur_bank = bank;
        req_valid = 1'b1; req_op = 3'(op); req_bank = 2'(bank); req_page = page;
        req_col = col; req_spare_only = spare; req_wait = wt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    bit last_err;
    int last_cycles;
    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        last_cycles = n;
        last_err = err;
        chk(done, tag, "done seen before bench limit", done, 1);
        repeat (3) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk(req_ready == 1'b1, "R9", "idle ready after reset", req_ready, 1);
        chk(nf_ce_n == 4'hF, "R8", "enables high after reset", nf_ce_n, 4'hF);
        chk(!done && !err, "R10", "no done/err after reset", {done, err}, 0);
        chk(nf_we_n && nf_re_n, "R8", "strobes idle after reset", {nf_we_n, nf_re_n}, 2'b11);
    endtask

    task automatic t_reset_op();
        clear_mon();
        nf_rdy[1] = 1'b0;
        start_op(0, 1, 24'h0, 16'h0, 0, 0);
        repeat (15) @(negedge clk);
        chk(!done && done_n == 0, "R1", "no completion while bank busy", done_n, 0);
        nf_rdy[1] = 1'b1;
        wait_done("R1");
        ex(C(8'hFF)); check_log("R1");
        chk(clr_n == 1, "R1", "fifo_clr pulses", clr_n, 1);
        chk(last_err == 0, "R1", "err", last_err, 0);
        chk(ce_viol == 0, "R8", "chip enable violations (reset)", ce_viol, 0);
    endtask

    task automatic t_readid();
        clear_mon();
        start_op(1, 0, 24'h0, 16'h0, 0, 0);
        wait_done("R2");
        ex(C(8'h90)); ex(A(8'h00)); check_log("R2");
        chk(id_word == 32'h9510DAEC, "R2", "identifier word", id_word, 32'h9510DAEC);
    endtask

    task automatic t_read(input string tag, input int bank, input bit spare,
                          input logic [15:0] col, input int nbytes, input int polls);
        clear_mon();
        polls_needed = polls;
        start_op(2, bank, 24'h123456, col, spare, 0);
        wait_done(tag);
        ex(C(8'h00));
        if (spare) begin ex(A(8'h00)); ex(A(8'h08)); end
        else begin ex(A(col[7:0])); ex(A(col[15:8])); end
        ex(A(8'h56)); ex(A(8'h34)); ex(A(8'h12));
        ex(C(8'h30)); ex(C(8'h70)); ex(C(8'h00));
        check_log(tag);
        chk(stat_reads == polls + 1, tag, "status reads", stat_reads, polls + 1);
        chk(rd_seen == nbytes, tag, "bytes streamed", rd_seen, nbytes);
        chk(rd_bad == 0, tag, "stream byte mismatches", rd_bad, 0);
        chk(ce_viol == 0, "R8", "chip enable violations (read)", ce_viol, 0);
    endtask

    task automatic t_prog(input bit wt);
        clear_mon();
        polls_needed = 2;
        start_op(3, 1, 24'h00A0B1, 16'h0004, 0, wt);
        wait_done("R5");
        ex(C(8'h80)); ex(A(8'h04)); ex(A(8'h00));
        ex(A(8'hB1)); ex(A(8'hA0)); ex(A(8'h00)); ex(C(8'h10));
        if (wt) begin ex(C(8'h70)); ex(C(8'h00)); end
        check_log("R5");
        chk(wr_seen == 2112, "R5", "data strobes", wr_seen, 2112);
        chk(wr_bad == 0, "R5", "written byte mismatches", wr_bad, 0);
        chk(stat_reads == (wt ? 3 : 0), "R5", "status reads", stat_reads, wt ? 3 : 0);
    endtask

    task automatic t_prog_spare();
        clear_mon();
        start_op(3, 2, 24'h000007, 16'h0123, 1, 0);
        wait_done("R4");
        ex(C(8'h80)); ex(A(8'h00)); ex(A(8'h08));
        ex(A(8'h07)); ex(A(8'h00)); ex(A(8'h00)); ex(C(8'h10));
        check_log("R4");
        chk(wr_seen == 64, "R4", "spare-only program strobes", wr_seen, 64);
    endtask

    task automatic t_erase();
        clear_mon();
        polls_needed = 1;
        start_op(4, 3, 24'hABCDEF, 16'hFFFF, 0, 0);
        wait_done("R6");
        ex(C(8'h60)); ex(A(8'hEF)); ex(A(8'hCD)); ex(A(8'hAB));
        ex(C(8'hD0)); ex(C(8'h70)); ex(C(8'h00));
        check_log("R6");
        chk(last_err == 0, "R6", "err", last_err, 0);
        chk(ce_viol == 0, "R8", "chip enable violations (erase)", ce_viol, 0);
    endtask

    task automatic t_poll_timeout();
        clear_mon();
        polls_needed = 100000;
        start_op(4, 0, 24'h000100, 16'h0, 0, 0);
        wait_done("R7");
        ex(C(8'h60)); ex(A(8'h00)); ex(A(8'h01)); ex(A(8'h00));
        ex(C(8'hD0)); ex(C(8'h70));
        check_log("R7");
        chk(last_err == 1, "R7", "err on status timeout", last_err, 1);
        chk(last_cycles >= TMO, "R7", "timeout not early", last_cycles, TMO);
        chk(nf_ce_n == 4'hF, "R8", "enables released after abort", nf_ce_n, 4'hF);
        chk(err_lone == 0 && done_long == 0, "R10", "done/err shape", err_lone + done_long, 0);
    endtask

    task automatic t_ready_timeout();
        clear_mon();
        nf_rdy[0] = 1'b0;
        start_op(0, 0, 24'h0, 16'h0, 0, 0);
        wait_done("R7");
        nf_rdy[0] = 1'b1;
        chk(last_err == 1, "R7", "err on ready-line timeout", last_err, 1);
        chk(clr_n == 0, "R7", "no fifo_clr after timeout", clr_n, 0);
        ex(C(8'hFF)); check_log("R7");
    endtask

    task automatic t_busy_ignored();
        clear_mon();
        polls_needed = 0;
        start_op(2, 2, 24'h123456, 16'h0010, 0, 0);
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4; req_bank = 2'd3; req_page = 24'h0;
        @(negedge clk) req_valid = 1'b0;
        wait_done("R9");
        repeat (10) @(negedge clk);
        ex(C(8'h00)); ex(A(8'h10)); ex(A(8'h00));
        ex(A(8'h56)); ex(A(8'h34)); ex(A(8'h12));
        ex(C(8'h30)); ex(C(8'h70)); ex(C(8'h00));
        check_log("R9");
        chk(done_n == 1, "R9", "single completion", done_n, 1);
        chk(ce_viol == 0, "R9", "bank unchanged by busy request", ce_viol, 0);
        chk(done_long == 0, "R10", "done wider than one cycle", done_long, 0);
    endtask

    // ---------------- sequencing and watchdog ----------------
    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reset_op();
        t_readid();
        t_read("R3", 2, 0, 16'h0010, 2112, 3);
        t_read("R4", 3, 1, 16'h0000, 64, 0);
        t_prog(1'b1);
        t_prog(1'b0);
        t_prog_spare();
        t_erase();
        t_poll_timeout();
        t_ready_timeout();
        t_busy_ignored();
        summary();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

endmodule